// File: doc/BRIEF.md
# Command Response Buffer Controller

This block is the control and status register front end of a TPM-style command/response buffer interface. A host reaches it over a simple byte-addressable register bus. Each 4 KiB window of the address space stands for one locality, and the locality number is taken from the address bits at and above bit 12. The block tracks four things: whether the device is idle or ready, which locality owns the interface, whether a command is in flight, and whether a fatal completion error has occurred. It drives an external command engine through a narrow handshake. It sends a one-cycle start pulse and a one-cycle cancel pulse, and it receives a done strobe that carries an error flag.

Three small state machines hold the state of the block:
- The locality machine has the states `LOC_FREE` and `LOC_OWNED`. The transition *grant* (request-access write) moves it from either state to `LOC_OWNED` and records the writer as owner. The transition *release* (relinquish write) moves it to `LOC_FREE`.
- The readiness machine has the states `RDY_IDLE` and `RDY_ACTIVE`. The transition *wake* (command-ready write) moves it to `RDY_ACTIVE`. The transition *sleep* (go-idle write) moves it to `RDY_IDLE`.
- The command sequencer has the states `SEQ_IDLE` and `SEQ_BUSY`. The transition *launch* (accepted start) moves it to `SEQ_BUSY`. The transition *finish* (done strobe) moves it back to `SEQ_IDLE`.

Reads are registered. Read data appears one clock after a cycle with `bus_rd_i` high, and it holds until the next read.

Top module: `crb_ctrl_top`

Register offsets inside a locality window:

| Offset | Access | Contents |
|---|---|---|
| 0x000 | read | locality state |
| 0x008 | write | locality control |
| 0x00C | read | locality status |
| 0x030 | read | interface ID |
| 0x040 | write | control request |
| 0x044 | read | control status |
| 0x048 | write | cancel |
| 0x04C | read/write | start |
| 0x058 | read | command size |
| 0x05C | read | command address |
| 0x064 | read | response size |
| 0x068 | read | response address |

Every other offset reads as zero.

## Requirements
- R1: After reset the registers read as follows. Locality state = 0x0000FF80 when `tpm_established_i` is 1. Control status = 0x2. Start = 0. Locality status = 0. Interface ID = 0x00025811, made of type 1 in [3:0], version 1 in [7:4], transfer code 3 in [12:11], buffer capability 1 in [14] and selector 1 in [18:17], with all other fields 0. Command and response size = 0xF80 (window size minus the data-buffer offset 0x80). Command and response address = 0xFED40080 (base plus 0x80).
- R2: A write of exactly 1 to control request clears the idle bit, which is bit 1 of control status. A write of exactly 2 sets it. Any other value leaves it unchanged.
- R3: A write of exactly 1 to locality control has three effects. It sets granted (bit 0 of locality status). It clears seized (bit 1). It makes the writing locality the owner. Locality state then shows bit 1 = 1 and the owner in bits [15:8].
- R4: A write of exactly 2 to locality control clears assigned and granted. A write of 8, or of any other value, has no effect. While no locality is assigned, bits [15:8] of locality state read 0xFF.
- R5: A start write is accepted only when all three of these hold: the value is exactly 1, no command is in flight, and the writing locality is the assigned owner. An accepted start raises `eng_start_o` for exactly one cycle, in the cycle after the write. Start bit 0 then reads 1.
- R6: A write of exactly 1 to cancel raises `eng_cancel_o` for one cycle, in the cycle after the write, but only while a command is in flight. At any other time it is ignored.
- R7: A done strobe while a command is in flight clears start bit 0. If the strobe carries an error, it sets the fatal bit (bit 0 of control status), and that bit stays set until reset. A done strobe while no command is in flight has no effect.
- R8: Bit 0 of locality state reads as the inverse of `tpm_established_i`, sampled at the read.
- R9: A read at byte offset k within a word returns that whole word shifted right by 8·k bits.
- R10: Writes act only at the exact register offsets. A write to any other byte address, including an unaligned address inside a register, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low synchronous reset |
| bus_wr_i | input | 1 | write strobe |
| bus_rd_i | input | 1 | read strobe |
| bus_addr_i | input | ADDR_W (15) | byte address; bits at and above 12 select the locality |
| bus_wdata_i | input | 32 | write data |
| bus_rdata_o | output | 32 | registered read data |
| tpm_established_i | input | 1 | established flag from the engine |
| eng_start_o | output | 1 | one-cycle start request |
| eng_cancel_o | output | 1 | one-cycle cancel request |
| eng_done_i | input | 1 | completion strobe |
| eng_err_i | input | 1 | completion error, valid with done |

## Verification
The bench goes after the following corner cases:
- A start from a locality that is not the owner. If the ownership check were loose, the design would launch a command for the wrong caller.
- A second start while a command is busy. A design that got this wrong would pulse the engine twice.
- A start value of 3, and a start written to an unaligned address inside the start register. A design without full-value compares or exact decode would accept these.
- A cancel after completion, and a done strobe with the error flag while nothing is in flight. A design that did not gate these on the busy state would pulse cancel spuriously or set the fatal bit.
- The 0xFF active-locality value after relinquish, and the right shift applied to unaligned reads. These are checked against a model of the registers during a long random mix of writes, reads and completions.

// File: rtl/crb_pkg.sv
package crb_pkg;

    typedef enum logic [0:0] {LOC_FREE, LOC_OWNED}  loc_state_e;
    typedef enum logic [0:0] {RDY_IDLE, RDY_ACTIVE} rdy_state_e;
    typedef enum logic [0:0] {SEQ_IDLE, SEQ_BUSY}   seq_state_e;

    localparam int OFS_W = 12;

    localparam logic [OFS_W-1:0] OFS_LOC_STATE  = 12'h000;
    localparam logic [OFS_W-1:0] OFS_LOC_CTRL   = 12'h008;
    localparam logic [OFS_W-1:0] OFS_LOC_STS    = 12'h00C;
    localparam logic [OFS_W-1:0] OFS_INTF_ID    = 12'h030;
    localparam logic [OFS_W-1:0] OFS_CTRL_REQ   = 12'h040;
    localparam logic [OFS_W-1:0] OFS_CTRL_STS   = 12'h044;
    localparam logic [OFS_W-1:0] OFS_CANCEL     = 12'h048;
    localparam logic [OFS_W-1:0] OFS_START      = 12'h04C;
    localparam logic [OFS_W-1:0] OFS_CMD_SIZE   = 12'h058;
    localparam logic [OFS_W-1:0] OFS_CMD_ADDR   = 12'h05C;
    localparam logic [OFS_W-1:0] OFS_RSP_SIZE   = 12'h064;
    localparam logic [OFS_W-1:0] OFS_RSP_ADDR   = 12'h068;

    localparam logic [31:0] CODE_REQUEST    = 32'd1;
    localparam logic [31:0] CODE_RELINQUISH = 32'd2;
    localparam logic [31:0] CODE_WAKE       = 32'd1;
    localparam logic [31:0] CODE_SLEEP      = 32'd2;
    localparam logic [31:0] CODE_INVOKE     = 32'd1;

    localparam logic [3:0] ID_TYPE     = 4'd1;
    localparam logic [3:0] ID_VERSION  = 4'd1;
    localparam logic [1:0] ID_XFER     = 2'b11;
    localparam logic       ID_BUF_CAP  = 1'b1;
    localparam logic [1:0] ID_SELECTOR = 2'd1;

    localparam logic [31:0] INTF_ID_WORD =
        (32'(ID_TYPE))           |
        (32'(ID_VERSION)  << 4)  |
        (32'(ID_XFER)     << 11) |
        (32'(ID_BUF_CAP)  << 14) |
        (32'(ID_SELECTOR) << 17);

endpackage

// File: rtl/crb_loc_fsm.sv
module crb_loc_fsm
    import crb_pkg::*;
#(
    parameter int LOC_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             req_i,
    input  logic             rel_i,
    input  logic [LOC_W-1:0] wr_loc_i,
    output logic             owned_o,
    output logic [LOC_W-1:0] owner_o,
    output logic             granted_o,
    output logic             seized_o
);

    loc_state_e       st_q, st_d;
    logic [LOC_W-1:0] owner_q;
    logic             granted_q, seized_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= LOC_FREE;
        else         st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LOC_FREE:  if (req_i) st_d = LOC_OWNED;
            LOC_OWNED: if (rel_i) st_d = LOC_FREE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            owner_q   <= '0;
            granted_q <= 1'b0;
            seized_q  <= 1'b0;
        end else if (req_i) begin
            owner_q   <= wr_loc_i;
            granted_q <= 1'b1;
            seized_q  <= 1'b0;
        end else if (rel_i) begin
            granted_q <= 1'b0;
        end
    end

    assign owned_o   = (st_q == LOC_OWNED);
    assign owner_o   = owner_q;
    assign granted_o = granted_q;
    assign seized_o  = seized_q;

    a_r3_request_grants: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_i |=> (owned_o && granted_o && !seized_o && owner_o == $past(wr_loc_i)));

    a_r4_release_frees: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rel_i |=> (!owned_o && !granted_o));

endmodule

// File: rtl/crb_rdy_fsm.sv
module crb_rdy_fsm
    import crb_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic wake_i,
    input  logic sleep_i,
    output logic idle_o
);

    rdy_state_e st_q, st_d;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= RDY_IDLE;
        else         st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RDY_IDLE:   if (wake_i)  st_d = RDY_ACTIVE;
            RDY_ACTIVE: if (sleep_i) st_d = RDY_IDLE;
        endcase
    end

    assign idle_o = (st_q == RDY_IDLE);

    a_r2_wake_clears_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_i |=> !idle_o);

    a_r2_sleep_sets_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sleep_i |=> idle_o);

endmodule

// File: rtl/crb_cmd_seq.sv
module crb_cmd_seq
    import crb_pkg::*;
#(
    parameter int LOC_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_wr_i,
    input  logic             cancel_wr_i,
    input  logic [LOC_W-1:0] wr_loc_i,
    input  logic             owned_i,
    input  logic [LOC_W-1:0] owner_i,
    input  logic             eng_done_i,
    input  logic             eng_err_i,
    output logic             busy_o,
    output logic             fatal_o,
    output logic             eng_start_o,
    output logic             eng_cancel_o
);

    seq_state_e st_q, st_d;
    logic       start_ok;
    logic       start_q, cancel_q, fatal_q;

    assign start_ok = start_wr_i && owned_i && (owner_i == wr_loc_i);

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= SEQ_IDLE;
        else         st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SEQ_IDLE: if (start_ok)   st_d = SEQ_BUSY;
            SEQ_BUSY: if (eng_done_i) st_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            start_q  <= 1'b0;
            cancel_q <= 1'b0;
            fatal_q  <= 1'b0;
        end else begin
            start_q  <= (st_q == SEQ_IDLE) && start_ok;
            cancel_q <= (st_q == SEQ_BUSY) && cancel_wr_i;
            if ((st_q == SEQ_BUSY) && eng_done_i && eng_err_i) fatal_q <= 1'b1;
        end
    end

    assign busy_o       = (st_q == SEQ_BUSY);
    assign fatal_o      = fatal_q;
    assign eng_start_o  = start_q;
    assign eng_cancel_o = cancel_q;

    a_r5_start_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        eng_start_o |=> !eng_start_o);

    a_r5_start_marks_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        eng_start_o |-> busy_o);

    a_r6_cancel_in_flight: assert property (@(posedge clk_i) disable iff (!rst_ni)
        eng_cancel_o |-> $past(busy_o));

    a_r7_finish_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> $past(eng_done_i));

    a_r7_fatal_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fatal_o |=> fatal_o);

endmodule

// File: rtl/crb_rd_mux.sv
module crb_rd_mux
    import crb_pkg::*;
#(
    parameter int          LOC_W    = 3,
    parameter logic [31:0] BUF_SIZE = 32'hF80,
    parameter logic [31:0] BUF_ADDR = 32'hFED40080
) (
    input  logic [OFS_W-1:2] word_i,
    input  logic             not_est_i,
    input  logic             owned_i,
    input  logic [LOC_W-1:0] owner_i,
    input  logic             granted_i,
    input  logic             seized_i,
    input  logic             idle_i,
    input  logic             fatal_i,
    input  logic             busy_i,
    output logic [31:0]      word_o
);

    logic [7:0] active_loc;

    assign active_loc = owned_i ? {{(8 - LOC_W){1'b0}}, owner_i} : 8'hFF;

    always_comb begin
        word_o = '0;
        unique case ({word_i, 2'b00})
            OFS_LOC_STATE: word_o = {16'h0, active_loc, 1'b1, 5'b0, owned_i, not_est_i};
            OFS_LOC_STS:   word_o = {30'h0, seized_i, granted_i};
            OFS_INTF_ID:   word_o = INTF_ID_WORD;
            OFS_CTRL_STS:  word_o = {30'h0, idle_i, fatal_i};
            OFS_START:     word_o = {31'h0, busy_i};
            OFS_CMD_SIZE:  word_o = BUF_SIZE;
            OFS_CMD_ADDR:  word_o = BUF_ADDR;
            OFS_RSP_SIZE:  word_o = BUF_SIZE;
            OFS_RSP_ADDR:  word_o = BUF_ADDR;
            default:       word_o = '0;
        endcase
    end

endmodule

// File: rtl/crb_ctrl_top.sv
module crb_ctrl_top
    import crb_pkg::*;
#(
    parameter int          ADDR_W    = 15,
    parameter logic [31:0] BASE_ADDR = 32'hFED40000,
    parameter logic [31:0] WIN_BYTES = 32'h1000,
    parameter logic [31:0] BUF_OFS   = 32'h80
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    input  logic              tpm_established_i,
    output logic              eng_start_o,
    output logic              eng_cancel_o,
    input  logic              eng_done_i,
    input  logic              eng_err_i
);

    localparam int          LOC_W    = ADDR_W - OFS_W;
    localparam logic [31:0] BUF_SIZE = WIN_BYTES - BUF_OFS;
    localparam logic [31:0] BUF_ADDR = BASE_ADDR + BUF_OFS;

    logic [OFS_W-1:0] ofs;
    logic [LOC_W-1:0] wr_loc;
    logic             hit_req, hit_rel, hit_wake, hit_sleep, hit_start, hit_cancel;
    logic             owned, granted, seized, idle, busy, fatal;
    logic [LOC_W-1:0] owner;
    logic [31:0]      word, rdata_q;

    assign ofs    = bus_addr_i[OFS_W-1:0];
    assign wr_loc = bus_addr_i[ADDR_W-1:OFS_W];

    assign hit_req    = bus_wr_i && ofs == OFS_LOC_CTRL && bus_wdata_i == CODE_REQUEST;
    assign hit_rel    = bus_wr_i && ofs == OFS_LOC_CTRL && bus_wdata_i == CODE_RELINQUISH;
    assign hit_wake   = bus_wr_i && ofs == OFS_CTRL_REQ && bus_wdata_i == CODE_WAKE;
    assign hit_sleep  = bus_wr_i && ofs == OFS_CTRL_REQ && bus_wdata_i == CODE_SLEEP;
    assign hit_start  = bus_wr_i && ofs == OFS_START    && bus_wdata_i == CODE_INVOKE;
    assign hit_cancel = bus_wr_i && ofs == OFS_CANCEL   && bus_wdata_i == CODE_INVOKE;

    crb_loc_fsm #(.LOC_W(LOC_W)) u_loc (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .req_i     (hit_req),
        .rel_i     (hit_rel),
        .wr_loc_i  (wr_loc),
        .owned_o   (owned),
        .owner_o   (owner),
        .granted_o (granted),
        .seized_o  (seized)
    );

    crb_rdy_fsm u_rdy (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wake_i  (hit_wake),
        .sleep_i (hit_sleep),
        .idle_o  (idle)
    );

    crb_cmd_seq #(.LOC_W(LOC_W)) u_seq (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .start_wr_i   (hit_start),
        .cancel_wr_i  (hit_cancel),
        .wr_loc_i     (wr_loc),
        .owned_i      (owned),
        .owner_i      (owner),
        .eng_done_i   (eng_done_i),
        .eng_err_i    (eng_err_i),
        .busy_o       (busy),
        .fatal_o      (fatal),
        .eng_start_o  (eng_start_o),
        .eng_cancel_o (eng_cancel_o)
    );

    crb_rd_mux #(
        .LOC_W    (LOC_W),
        .BUF_SIZE (BUF_SIZE),
        .BUF_ADDR (BUF_ADDR)
    ) u_rd (
        .word_i    (ofs[OFS_W-1:2]),
        .not_est_i (!tpm_established_i),
        .owned_i   (owned),
        .owner_i   (owner),
        .granted_i (granted),
        .seized_i  (seized),
        .idle_i    (idle),
        .fatal_i   (fatal),
        .busy_i    (busy),
        .word_o    (word)
    );

    always_ff @(posedge clk_i) begin
        if (!rst_ni)       rdata_q <= '0;
        else if (bus_rd_i) rdata_q <= word >> {ofs[1:0], 3'b000};
    end

    assign bus_rdata_o = rdata_q;

    a_r10_no_start_off_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_wr_i && ofs != OFS_START && !busy) |=> !eng_start_o);

endmodule

// File: tb/sim_crb_ctrl_top.sv
module sim_crb_ctrl_top;

    localparam logic [11:0] A_LSTATE = 12'h000, A_LCTRL = 12'h008, A_LSTS = 12'h00C,
                            A_ID = 12'h030, A_REQ = 12'h040, A_STS = 12'h044,
                            A_CAN = 12'h048, A_GO = 12'h04C, A_CSZ = 12'h058,
                            A_CAD = 12'h05C, A_RSZ = 12'h064, A_RAD = 12'h068;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        wr = 1'b0, rd = 1'b0, est = 1'b1, done = 1'b0, err = 1'b0;
    logic [14:0] addr = '0;
    logic [31:0] wdata = '0, rdata;
    logic        start_p, cancel_p;

    int n_chk = 0, n_bad = 0;

    logic       m_asg = 0, m_grant = 0, m_idle = 1, m_busy = 0, m_fatal = 0;
    logic [2:0] m_loc = 0;

    always #10 clk = ~clk;

    crb_ctrl_top u0 (
        .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .tpm_established_i(est),
        .eng_start_o(start_p), .eng_cancel_o(cancel_p), .eng_done_i(done), .eng_err_i(err)
    );

    function automatic logic [31:0] exp_word(input logic [11:0] o);
        case ({o[11:2], 2'b00})
            A_LSTATE: return {16'h0, m_asg ? {5'b0, m_loc} : 8'hFF, 1'b1, 5'b0, m_asg, ~est};
            A_LSTS:   return {31'h0, m_grant};
            A_ID:     return 32'h00025811;
            A_STS:    return {30'h0, m_idle, m_fatal};
            A_GO:     return {31'h0, m_busy};
            A_CSZ, A_RSZ: return 32'hF80;
            A_CAD, A_RAD: return 32'hFED40080;
            default:  return 32'h0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_read(input logic [14:0] a, input string req);
        logic [31:0] e;
        @(negedge clk); rd = 1'b1; addr = a;
        e = exp_word(a[11:0]) >> (8 * a[1:0]);
        @(negedge clk); rd = 1'b0;
        check(req, rdata, e);
    endtask

    task automatic do_write(input logic [14:0] a, input logic [31:0] d, input string req);
        logic es = 0, ec = 0;
        @(negedge clk); wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr = 1'b0;
        case (a[11:0])
            A_LCTRL: if (d == 1) begin m_asg = 1; m_grant = 1; m_loc = a[14:12]; end
                     else if (d == 2) begin m_asg = 0; m_grant = 0; end
            A_REQ:   if (d == 1) m_idle = 0; else if (d == 2) m_idle = 1;
            A_CAN:   if (d == 1 && m_busy) ec = 1;
            A_GO:    if (d == 1 && !m_busy && m_asg && m_loc == a[14:12]) begin m_busy = 1; es = 1; end
            default: ;
        endcase
        check({req, " start pulse"}, {31'h0, start_p}, {31'h0, es});
        check({req, " cancel pulse"}, {31'h0, cancel_p}, {31'h0, ec});
    endtask

    task automatic do_done(input logic e);
        @(negedge clk); done = 1'b1; err = e;
        @(negedge clk); done = 1'b0; err = 1'b0;
        if (m_busy) begin m_busy = 0; if (e) m_fatal = 1; end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [11:0] offs [12];
        void'($urandom(32'd20240607));
        offs = '{A_LSTATE, A_LCTRL, A_LSTS, A_ID, A_REQ, A_STS, A_CAN, A_GO, A_CSZ, A_CAD, A_RSZ, A_RAD};
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        do_read({3'd0, A_LSTATE}, "R1 loc state");
        check("R1 loc state literal", rdata, 32'h0000FF80);
        do_read({3'd0, A_STS}, "R1 ctrl sts");
        do_read({3'd0, A_ID}, "R1 intf id");
        do_read({3'd0, A_CSZ}, "R1 cmd size");
        do_read({3'd1, A_RAD}, "R1 rsp addr");
        do_read({3'd0, A_GO}, "R1 start");
        // R8 established inverse
        est = 1'b0;
        do_read({3'd0, A_LSTATE}, "R8 not established");
        est = 1'b1;
        // R5 start with no owner
        do_write({3'd0, A_GO}, 1, "R5 start unowned");
        // R3 request from locality 2
        do_write({3'd2, A_LCTRL}, 1, "R3 request");
        do_read({3'd0, A_LSTATE}, "R3 owner field");
        do_read({3'd0, A_LSTS}, "R3 granted");
        // R5 wrong locality, R10 wrong value / unaligned offset
        do_write({3'd1, A_GO}, 1, "R5 foreign locality");
        do_write({3'd2, A_GO}, 3, "R10 start value 3");
        do_write({3'd2, A_GO + 12'd1}, 1, "R10 unaligned start");
        do_write({3'd2, A_GO}, 1, "R5 owner start");
        @(negedge clk);
        check("R5 pulse single", {31'h0, start_p}, 32'h0);
        do_read({3'd2, A_GO}, "R5 invoke reads 1");
        do_write({3'd2, A_GO}, 1, "R5 start while busy");
        // R6 cancel while busy
        do_write({3'd0, A_CAN}, 1, "R6 cancel busy");
        // R7 completion
        do_done(1'b0);
        do_read({3'd2, A_GO}, "R7 invoke cleared");
        do_write({3'd0, A_CAN}, 1, "R6 cancel idle");
        do_done(1'b1);
        do_read({3'd0, A_STS}, "R7 stray done ignored");
        do_write({3'd2, A_GO}, 1, "R7 start for error");
        do_done(1'b1);
        do_read({3'd0, A_STS}, "R7 fatal set");
        // R4 no-effect code and relinquish
        do_write({3'd2, A_LCTRL}, 8, "R4 code 8");
        do_read({3'd2, A_LSTATE}, "R4 code 8 no effect");
        do_write({3'd2, A_LCTRL}, 2, "R4 relinquish");
        do_read({3'd2, A_LSTATE}, "R4 active reads FF");
        do_read({3'd2, A_LSTS}, "R4 granted cleared");
        // R9 unaligned reads
        do_read({3'd0, A_ID + 12'd1}, "R9 shift 1");
        do_read({3'd0, A_ID + 12'd2}, "R9 shift 2");
        do_read({3'd0, A_RAD + 12'd3}, "R9 shift 3");
        // R2 control request
        do_write({3'd0, A_REQ}, 1, "R2 wake");
        do_read({3'd0, A_STS}, "R2 idle cleared");
        do_write({3'd0, A_REQ}, 3, "R2 other value");
        do_read({3'd0, A_STS}, "R2 idle unchanged");
        do_write({3'd0, A_REQ}, 2, "R2 sleep");
        do_read({3'd0, A_STS}, "R2 idle set");

        // random mix (R2 R3 R4 R5 R6 R7 R9)
        for (int i = 0; i < 800; i++) begin
            int op = $urandom_range(0, 6);
            logic [2:0] lc = ($urandom_range(0, 1) == 1) ? m_loc : 3'($urandom_range(0, 3));
            case (op)
                0: do_write({lc, A_LCTRL}, 32'($urandom_range(0, 3)), "R3/R4 rand loc ctrl");
                1: do_write({lc, A_REQ}, 32'($urandom_range(0, 3)), "R2 rand req");
                2: do_write({lc, A_GO}, ($urandom_range(0, 3) == 0) ? 32'd3 : 32'd1, "R5 rand start");
                3: do_write({lc, A_CAN}, 1, "R6 rand cancel");
                4: do_done(($urandom_range(0, 7) == 0));
                5: est = 1'($urandom_range(0, 1));
                default: do_read({lc, offs[$urandom_range(0, 11)] + 12'($urandom_range(0, 3))}, "R9 rand read");
            endcase
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule